// File: doc/BRIEF.md
# Phase Comparator with Masked Lock Detector

This block is the digital front end of a spindle motor speed loop. It watches two already-synchronized digital levels: a reference clock and a tachometer pulse derived from the first Hall phase. The servo runs at a 1:1 ratio, with no divider, so each tach rising edge is paired with a reference falling edge. The block opens an error pulse at whichever of these two edges arrives first and closes it at the other. The pulse length in system clocks is the phase error. While no pulse is open, the error output is released (output enable low), so the error filter outside sees a midscale level.

Polarity follows the drive convention that a lower duty cycle asks for more current. When the reference edge arrives first, the tach lags and the error level is driven low (accelerate). When the tach edge arrives first, the level is driven high (decelerate). A status bit keeps the direction of the last completed pulse, so the drive stage can pick its higher or lower current limit.

A lock flag rises only after a run of slow timebase ticks with no out-of-window phase error. Any error pulse that reaches the programmable window drops the flag at once and restarts the run. This suppresses short drop-outs while the motor hunts during pull-in. There is no data stream here, so every pin is a plain level.

Top module: `pll_phase_lock`

## Requirements
- R1: After reset, err_oe = 0, err_out = 0, accel = 1 and lock = 0.
- R2: If the reference falls and the tach rises k cycles later (k >= 1), err_oe is high for exactly k consecutive cycles, with err_out = 0 in all of them (lag, accelerate).
- R3: If the tach rises and the reference falls k cycles later (k >= 1), err_oe is high for exactly k consecutive cycles, with err_out = 1 in all of them (lead, decelerate).
- R4: A reference falling edge and a tach rising edge seen in the same cycle with no pulse open produce no error pulse (err_oe stays 0).
- R5: A reference rising edge or a tach falling edge has no effect: no error pulse starts.
- R6: When a lag pulse closes, accel becomes 1. When a lead pulse closes, accel becomes 0. A coincident edge pair leaves accel unchanged.
- R7: With no failing pulse, lock rises in the cycle after the MASK_TICKS-th tick pulse (default 7) and stays high.
- R8: An error pulse of width >= win cycles clears lock in the cycle after its win-th cycle, and the tick count restarts from zero, so MASK_TICKS further ticks are needed to re-lock.
- R9: Error pulses shorter than win cycles leave lock and the tick count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | 1 | Synchronized reference clock level |
| tach_in | input | 1 | Synchronized tach level from the first Hall phase |
| tick | input | 1 | One-cycle slow timebase pulse |
| win | input | CNT_W | Lock window in system clocks |
| err_out | output | 1 | Error level: 0 = lag (accelerate), 1 = lead (decelerate) |
| err_oe | output | 1 | Error output enable; 0 = released to midscale |
| accel | output | 1 | Direction of the last completed pulse; 1 = accelerate |
| lock | output | 1 | Masked phase-lock flag |

## Verification
The embedded properties check, on every cycle, that a coincident edge pair with no pulse open starts nothing and that every pulse starts its width count at one. They also check that accel changes only when an open pulse closes, that a window failure drops lock on the next cycle, and that lock rises only right after a tick. Exact pulse widths and polarities under lag, lead and coincident patterns, the immunity to the opposite edges, and the full mask sequence with its restart after a failure can only be shown by the bench scenarios. The bench checks these against its own expected pulse queue and tick counts.

// File: rtl/pll_phase_pkg.sv
package pll_phase_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LAG  = 2'd1,
    PH_LEAD = 2'd2
  } ph_state_t;
endpackage

// File: rtl/pll_edge_det.sv
module pll_edge_det #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic edge_seen
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  generate
    if (RISING) begin : g_rise
      assign edge_seen = lvl & ~lvl_q;
    end else begin : g_fall
      assign edge_seen = ~lvl & lvl_q;
    end
  endgenerate
endmodule

// File: rtl/pll_phase_cmp.sv
module pll_phase_cmp
  import pll_phase_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_fall,
  input  logic             tach_rise,
  input  logic [CNT_W-1:0] win,
  output logic             active,
  output logic             lead,
  output logic             accel,
  output logic             fail
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  ph_state_t        state;
  logic [CNT_W-1:0] cnt;

  assign active = (state != PH_IDLE);
  assign lead   = (state == PH_LEAD);
  assign fail   = active && (cnt >= win);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PH_IDLE;
      cnt   <= '0;
      accel <= 1'b1;
    end else begin
      case (state)
        PH_IDLE: begin
          if (ref_fall && !tach_rise) begin
            state <= PH_LAG;
            cnt   <= CNT_ONE;
          end else if (tach_rise && !ref_fall) begin
            state <= PH_LEAD;
            cnt   <= CNT_ONE;
          end
        end
        PH_LAG: begin
          if (tach_rise) begin
            accel <= 1'b1;
            cnt   <= CNT_ONE;
            state <= ref_fall ? PH_LAG : PH_IDLE;
          end else if (cnt != CNT_MAX) begin
            cnt <= cnt + CNT_ONE;
          end
        end
        PH_LEAD: begin
          if (ref_fall) begin
            accel <= 1'b0;
            cnt   <= CNT_ONE;
            state <= tach_rise ? PH_LEAD : PH_IDLE;
          end else if (cnt != CNT_MAX) begin
            cnt <= cnt + CNT_ONE;
          end
        end
        default: state <= PH_IDLE;
      endcase
    end
  end

  p_coincident_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_IDLE && ref_fall && tach_rise) |=> !active);

  p_count_starts_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (cnt == CNT_ONE));

  p_accel_on_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(accel) |-> $past(active));
endmodule

// File: rtl/pll_lock_mask.sv
module pll_lock_mask #(
  parameter int MASK_TICKS = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic fail,
  output logic lock
);
  localparam int MW = $clog2(MASK_TICKS + 1);
  localparam logic [MW-1:0] M_TOP = MW'(MASK_TICKS);

  logic [MW-1:0] mcnt;

  assign lock = (mcnt == M_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              mcnt <= '0;
    else if (fail)           mcnt <= '0;
    else if (tick && !lock)  mcnt <= mcnt + 1'b1;
  end

  p_fail_drops_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> !lock);

  p_lock_after_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(tick));
endmodule

// File: rtl/pll_phase_lock.sv
module pll_phase_lock #(
  parameter int CNT_W      = 8,
  parameter int MASK_TICKS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             tach_in,
  input  logic             tick,
  input  logic [CNT_W-1:0] win,
  output logic             err_out,
  output logic             err_oe,
  output logic             accel,
  output logic             lock
);
  logic ref_fall;
  logic tach_rise;
  logic fail;

  pll_edge_det #(.RISING(1'b0)) u_ref_edge (
    .clk(clk), .rst_n(rst_n), .lvl(ref_in), .edge_seen(ref_fall)
  );

  pll_edge_det #(.RISING(1'b1)) u_tach_edge (
    .clk(clk), .rst_n(rst_n), .lvl(tach_in), .edge_seen(tach_rise)
  );

  pll_phase_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .ref_fall(ref_fall), .tach_rise(tach_rise),
    .win(win), .active(err_oe), .lead(err_out), .accel(accel), .fail(fail)
  );

  pll_lock_mask #(.MASK_TICKS(MASK_TICKS)) u_mask (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fail(fail), .lock(lock)
  );
endmodule

// File: tb/pll_phase_lock_bench.sv
module pll_phase_lock_bench;
  localparam int CNT_W = 8;
  localparam int MASK_TICKS = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b1;
  logic tach_in = 1'b0;
  logic tick = 1'b0;
  logic [CNT_W-1:0] win = 8'd10;
  logic err_out, err_oe, accel, lock;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int exp_w[$];
  bit exp_p[$];

  always #10 clk = ~clk;

  pll_phase_lock #(.CNT_W(CNT_W), .MASK_TICKS(MASK_TICKS)) u_pll_phase_lock (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .tach_in(tach_in), .tick(tick),
    .win(win), .err_out(err_out), .err_oe(err_oe), .accel(accel), .lock(lock)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic lag(input int k);
    exp_w.push_back(k); exp_p.push_back(1'b0);
    ref_in = 1'b0;
    repeat (k) @(negedge clk);
    tach_in = 1'b1;
    @(negedge clk);
    ref_in = 1'b1; tach_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R5 no pulse after opposite edges", int'(err_oe), 0);
  endtask

  task automatic lead(input int k);
    exp_w.push_back(k); exp_p.push_back(1'b1);
    tach_in = 1'b1;
    repeat (k) @(negedge clk);
    ref_in = 1'b0;
    @(negedge clk);
    ref_in = 1'b1; tach_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R5 no pulse after opposite edges", int'(err_oe), 0);
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  // monitor: measures each error pulse and compares with the queue
  initial begin
    int w = 0;
    bit pol = 1'b0;
    bit mixed = 1'b0;
    bit prev = 1'b0;
    forever begin
      @(negedge clk);
      if (err_oe) begin
        if (w == 0) pol = err_out;
        else if (err_out != pol) mixed = 1'b1;
        w++;
      end else if (prev) begin
        if (exp_w.size() == 0) begin
          check("R2/R3 unexpected pulse width", w, 0);
        end else begin
          int ew;
          bit ep;
          ew = exp_w.pop_front();
          ep = exp_p.pop_front();
          check(ep ? "R3 lead pulse width" : "R2 lag pulse width", w, ew);
          check(ep ? "R3 lead polarity" : "R2 lag polarity", int'(pol), int'(ep));
          check("R2 R3 steady polarity", int'(mixed), 0);
        end
        w = 0; mixed = 1'b0;
      end
      prev = err_oe;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 err_oe", int'(err_oe), 0);
    check("R1 err_out", int'(err_out), 0);
    check("R1 accel", int'(accel), 1);
    check("R1 lock", int'(lock), 0);

    lead(4);
    check("R6 accel after lead", int'(accel), 0);
    lag(5);
    check("R6 accel after lag", int'(accel), 1);
    lag(1);
    lead(1);
    check("R6 accel after short lead", int'(accel), 0);

    // coincident edges: no pulse, accel unchanged
    ref_in = 1'b0; tach_in = 1'b1;
    @(negedge clk);
    check("R4 coincident no pulse", int'(err_oe), 0);
    @(negedge clk);
    check("R4 coincident no pulse later", int'(err_oe), 0);
    check("R6 accel kept on coincidence", int'(accel), 0);
    ref_in = 1'b1; tach_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R5 opposite edges idle", int'(err_oe), 0);

    // mask sequence
    repeat (MASK_TICKS - 1) pulse_tick();
    check("R7 lock before last tick", int'(lock), 0);
    pulse_tick();
    check("R7 lock after last tick", int'(lock), 1);
    repeat (2) pulse_tick();
    check("R7 lock holds", int'(lock), 1);

    lag(9);
    check("R9 short lag keeps lock", int'(lock), 1);
    lead(9);
    check("R9 short lead keeps lock", int'(lock), 1);

    lag(10);
    check("R8 lag at window clears lock", int'(lock), 0);
    repeat (MASK_TICKS - 1) pulse_tick();
    check("R8 restart needs full count", int'(lock), 0);
    pulse_tick();
    check("R8 relock after full count", int'(lock), 1);
    lead(12);
    check("R8 lead over window clears lock", int'(lock), 0);

    repeat (5) @(negedge clk);
    check("R2 R3 all pulses seen", exp_w.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule